// File: doc/BRIEF.md
# Dual-Port Configuration Register Access Controller

This block keeps a small PCI-style configuration space that two masters share: a local system-bus port and a PCI target port. Every access is classified by register group, by a static host/device mode strap, and by a run-time ownership bit called the hold bit. From these three inputs the block decides whether a read returns stored data or a fixed filler word, whether a write lands or is dropped, and whether a PCI request must be retried.

After reset the hold bit is set, so the local side owns the space and PCI reads are retried. Local firmware programs the map, subsystem and identity-override registers, then clears the hold bit and issues a dummy read to flush that write. From then on, PCI sees the identity words and the standard registers, while the local side can still write its own registers but reads back only filler. The identity-override registers exist only when the revision parameter is 3 or more. Below that, their offsets act as plain standard registers.

Both ports answer exactly one cycle after a request. Addresses are byte offsets on dword boundaries. The low two address bits are ignored. The groups are:
- identity: 0x00 (device/vendor word), 0x08 (class/revision word) and 0x2C (subsystem word, mirrored from 0x8C);
- local-owned: 0x44 to 0x80, plus 0x8C and 0x90;
- identity-override: 0x9C and 0xA0;
- hold control: 0xFC;
- standard: every other offset.

Top module: `cfg_space_arbiter`

## Requirements
- R1: After reset the hold bit (bit 0 at offset 0xFC) reads 1 from the local port. The identity word at 0x00 holds the ID_WORD parameter. Neither port asserts a response.
- R2: In device mode with hold set, every PCI read gets response code 1 (retry).
- R3: In device mode with hold set, every PCI write gets response code 2 (ignored) and changes no register.
- R4: A local write to 0xFC sets hold to write-data bit 0. In device mode with hold clear, every local read except 0xFC returns 0xDEADBEEF.
- R5: In device mode with hold set, local reads of the identity, local-owned and override groups return stored data. Local reads of standard registers return 0xDEADBEEF. Local writes to the identity group are dropped.
- R6: In device mode, local writes to the local-owned and override groups take effect whatever the state of hold. A word written at 0x9C replaces the 0x00 word, and a word written at 0xA0 replaces the 0x08 word.
- R7: In device mode with hold clear:
  - PCI reads of the identity and standard groups return stored data with response code 0 (done).
  - PCI writes to standard registers update only the enabled bytes and get code 0.
  - PCI writes to any other group get code 2.
  - PCI reads of the local-owned group return 0xDEADBEEF.
- R8: The word at 0x2C, as read from PCI, always equals the last word written locally at 0x8C.
- R9: In host mode:
  - Local reads return stored data for every group.
  - Local writes update every group except identity.
  - PCI reads return 0xDEADBEEF with code 0.
  - PCI writes get code 2 and change nothing.
- R10: With REV below 3, offsets 0x9C and 0xA0 behave as standard registers, and 0x00 and 0x08 stay at their parameter values.
- R11: When both ports request in the same cycle, the local access is served and the PCI access gets code 1.
- R12: Each port raises its response valid for exactly one cycle, in the cycle after each request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_mode | input | 1 | 1 = host mode, 0 = device mode (static) |
| loc_req | input | 1 | Local access request |
| loc_we | input | 1 | Local write (1) or read (0) |
| loc_addr | input | AW | Local byte offset |
| loc_wdata | input | 32 | Local write data |
| loc_ack | output | 1 | Local response valid |
| loc_rdata | output | 32 | Local read data |
| pci_req | input | 1 | PCI access request |
| pci_we | input | 1 | PCI write (1) or read (0) |
| pci_addr | input | AW | PCI byte offset |
| pci_wdata | input | 32 | PCI write data |
| pci_be | input | 4 | PCI byte enables |
| pci_rsp_valid | output | 1 | PCI response valid |
| pci_rsp | output | 2 | 0 done, 1 retry, 2 ignored |
| pci_rdata | output | 32 | PCI read data |

## Verification
A hold bit in the wrong state shows up one cycle after the next PCI read: a retry arrives where data was due, or the reverse. A wrong group decode shows up as filler where stored data belongs, or as a write that lands when it should have been dropped. The bench reads such writes back through the port that is allowed to see them, on the next access. The override and subsystem paths are checked across ports: the local side writes, and the next PCI read of the mirrored word must show the new value.

// File: rtl/cfg_space_arbiter.sv
module cfg_space_arbiter #(
  parameter int          REV        = 3,
  parameter int          AW         = 8,
  parameter logic [31:0] ID_WORD    = 32'h5A17_10EE,
  parameter logic [31:0] CLASS_WORD = 32'h0B40_0003,
  parameter logic [31:0] FILLER     = 32'hDEAD_BEEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_mode,
  input  logic          loc_req,
  input  logic          loc_we,
  input  logic [AW-1:0] loc_addr,
  input  logic [31:0]   loc_wdata,
  output logic          loc_ack,
  output logic [31:0]   loc_rdata,
  input  logic          pci_req,
  input  logic          pci_we,
  input  logic [AW-1:0] pci_addr,
  input  logic [31:0]   pci_wdata,
  input  logic [3:0]    pci_be,
  output logic          pci_rsp_valid,
  output logic [1:0]    pci_rsp,
  output logic [31:0]   pci_rdata
);
  localparam int NW       = 1 << (AW - 2);
  localparam int W_ID     = 0;
  localparam int W_CLASS  = 2;
  localparam int W_SUBRD  = 11;
  localparam int W_MAPLO  = 17;
  localparam int W_MAPHI  = 32;
  localparam int W_SUBSET = 35;
  localparam int W_INT    = 36;
  localparam int W_IDSET  = 39;
  localparam int W_CLSET  = 40;
  localparam int W_HOLD   = NW - 1;
  localparam logic [1:0] RSP_DONE  = 2'd0;
  localparam logic [1:0] RSP_RETRY = 2'd1;
  localparam logic [1:0] RSP_IGN   = 2'd2;

  typedef enum logic [2:0] {G_ID, G_LOC, G_SET, G_OTH, G_HOLD} grp_t;

  logic [31:0] regs [NW];
  logic        hold;

  function automatic grp_t grp_of(input logic [AW-1:0] a);
    int w;
    w = int'(a[AW-1:2]);
    if (w == W_ID || w == W_CLASS || w == W_SUBRD)                  return G_ID;
    if ((w >= W_MAPLO && w <= W_MAPHI) || w == W_SUBSET || w == W_INT) return G_LOC;
    if (REV >= 3 && (w == W_IDSET || w == W_CLSET))                 return G_SET;
    if (w == W_HOLD)                                                return G_HOLD;
    return G_OTH;
  endfunction

  function automatic logic [31:0] word_of(input logic [AW-1:0] a);
    int w;
    w = int'(a[AW-1:2]);
    if (w == W_ID)    return (REV >= 3) ? regs[W_IDSET] : ID_WORD;
    if (w == W_CLASS) return (REV >= 3) ? regs[W_CLSET] : CLASS_WORD;
    if (w == W_SUBRD) return regs[W_SUBSET];
    if (w == W_HOLD)  return {31'd0, hold};
    return regs[w];
  endfunction

  grp_t l_grp, p_grp;
  assign l_grp = grp_of(loc_addr);
  assign p_grp = grp_of(pci_addr);

  logic l_rd_ok, l_wr_ok, p_retry, p_rd_ok, p_wr_ok, p_wr_go, l_wr_go;
  assign l_rd_ok = host_mode || l_grp == G_HOLD || (hold && l_grp != G_OTH);
  assign l_wr_ok = l_grp == G_HOLD || (l_grp != G_ID && (host_mode || l_grp != G_OTH));
  assign p_retry = loc_req || (!host_mode && hold && !pci_we);
  assign p_rd_ok = !host_mode && !hold && (p_grp == G_ID || p_grp == G_OTH);
  assign p_wr_ok = !host_mode && !hold && p_grp == G_OTH;
  assign l_wr_go = loc_req && loc_we && l_wr_ok;
  assign p_wr_go = pci_req && pci_we && !p_retry && p_wr_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) regs[i] <= '0;
      if (REV >= 3) begin
        regs[W_IDSET] <= ID_WORD;
        regs[W_CLSET] <= CLASS_WORD;
      end
      hold <= 1'b1;
    end else if (l_wr_go) begin
      if (l_grp == G_HOLD) hold <= loc_wdata[0];
      else regs[loc_addr[AW-1:2]] <= loc_wdata;
    end else if (p_wr_go) begin
      for (int b = 0; b < 4; b++)
        if (pci_be[b]) regs[pci_addr[AW-1:2]][8*b +: 8] <= pci_wdata[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loc_ack       <= 1'b0;
      loc_rdata     <= '0;
      pci_rsp_valid <= 1'b0;
      pci_rsp       <= RSP_DONE;
      pci_rdata     <= '0;
    end else begin
      loc_ack       <= loc_req;
      if (loc_req && !loc_we) loc_rdata <= l_rd_ok ? word_of(loc_addr) : FILLER;
      pci_rsp_valid <= pci_req;
      if (pci_req) begin
        if (p_retry)     pci_rsp <= RSP_RETRY;
        else if (pci_we) pci_rsp <= p_wr_ok ? RSP_DONE : RSP_IGN;
        else             pci_rsp <= RSP_DONE;
        pci_rdata <= (!p_retry && !pci_we && p_rd_ok) ? word_of(pci_addr) : FILLER;
      end
    end
  end

  // R12
  pci_rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pci_req |=> pci_rsp_valid);
  // R12
  loc_ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !loc_req |=> !loc_ack);
  // R2
  held_read_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pci_req && !pci_we && !host_mode && hold |=> pci_rsp == RSP_RETRY);
  // R3
  held_write_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pci_req && pci_we && !loc_req && !host_mode && hold |=> pci_rsp == RSP_IGN);
  // R11
  collide_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pci_req && loc_req |=> pci_rsp == RSP_RETRY && loc_ack);
  // R4
  released_filler_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_req && !loc_we && !host_mode && !hold && l_grp != G_HOLD |=> loc_rdata == FILLER);
  // R9
  host_no_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_mode && pci_req && !loc_req |=> pci_rsp != RSP_RETRY);
endmodule

// File: tb/cfg_space_arbiter_tb.sv
module cfg_space_arbiter_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, host_mode;
  logic        loc_req, loc_we, pci_req, pci_we;
  logic [7:0]  loc_addr, pci_addr;
  logic [31:0] loc_wdata, pci_wdata;
  logic [3:0]  pci_be;
  logic        loc_ack, pci_rsp_valid, o_loc_ack, o_pci_rsp_valid;
  logic [31:0] loc_rdata, pci_rdata, o_loc_rdata, o_pci_rdata;
  logic [1:0]  pci_rsp, o_pci_rsp;

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] ID0 = 32'h5A17_10EE;
  localparam logic [31:0] CL0 = 32'h0B40_0003;
  localparam logic [31:0] FIL = 32'hDEAD_BEEF;

  cfg_space_arbiter u_dut (.clk, .rst_n, .host_mode, .loc_req, .loc_we, .loc_addr, .loc_wdata,
    .loc_ack, .loc_rdata, .pci_req, .pci_we, .pci_addr, .pci_wdata, .pci_be,
    .pci_rsp_valid, .pci_rsp, .pci_rdata);

  cfg_space_arbiter #(.REV(2)) u_old (.clk, .rst_n, .host_mode, .loc_req, .loc_we, .loc_addr,
    .loc_wdata, .loc_ack(o_loc_ack), .loc_rdata(o_loc_rdata), .pci_req, .pci_we, .pci_addr,
    .pci_wdata, .pci_be, .pci_rsp_valid(o_pci_rsp_valid), .pci_rsp(o_pci_rsp),
    .pci_rdata(o_pci_rdata));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic do_reset(input logic hm);
    @(negedge clk);
    rst_n = 1'b0; host_mode = hm; loc_req = 0; pci_req = 0; loc_we = 0; pci_we = 0;
    loc_addr = 0; pci_addr = 0; loc_wdata = 0; pci_wdata = 0; pci_be = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic loc_acc(input logic we, input logic [7:0] a, input logic [31:0] d,
                         output logic [31:0] rd);
    @(negedge clk);
    loc_req = 1; loc_we = we; loc_addr = a; loc_wdata = d;
    @(negedge clk);
    loc_req = 0;
    chk("R12 local ack", {31'd0, loc_ack}, 32'd1);
    rd = loc_rdata;
    @(negedge clk);
    chk("R12 local ack drops", {31'd0, loc_ack}, 32'd0);
  endtask

  task automatic pci_acc(input logic we, input logic [7:0] a, input logic [31:0] d,
                         input logic [3:0] be, output logic [1:0] rsp, output logic [31:0] rd);
    @(negedge clk);
    pci_req = 1; pci_we = we; pci_addr = a; pci_wdata = d; pci_be = be;
    @(negedge clk);
    pci_req = 0;
    chk("R12 pci valid", {31'd0, pci_rsp_valid}, 32'd1);
    rsp = pci_rsp; rd = pci_rdata;
    @(negedge clk);
    chk("R12 pci valid drops", {31'd0, pci_rsp_valid}, 32'd0);
  endtask

  task automatic t_reset;
    logic [31:0] rd;
    do_reset(1'b0);
    @(negedge clk);
    chk("R1 no local ack", {31'd0, loc_ack}, 0);
    chk("R1 no pci rsp", {31'd0, pci_rsp_valid}, 0);
    loc_acc(0, 8'hFC, 0, rd); chk("R1 hold set", rd, 1);
    loc_acc(0, 8'h00, 0, rd); chk("R1 id word", rd, ID0);
  endtask

  task automatic t_held;
    logic [31:0] rd; logic [1:0] rsp;
    pci_acc(0, 8'h00, 0, 4'hF, rsp, rd); chk("R2 retry id", {30'd0, rsp}, 1);
    pci_acc(0, 8'h40, 0, 4'hF, rsp, rd); chk("R2 retry std", {30'd0, rsp}, 1);
    pci_acc(1, 8'h44, 32'h1111_2222, 4'hF, rsp, rd); chk("R3 ignored", {30'd0, rsp}, 2);
    loc_acc(0, 8'h44, 0, rd); chk("R3 map unchanged", rd, 0);
    loc_acc(1, 8'h44, 32'hCAFE_0044, rd);
    loc_acc(0, 8'h44, 0, rd); chk("R5 map readback", rd, 32'hCAFE_0044);
    loc_acc(1, 8'h00, 32'h0, rd);
    loc_acc(0, 8'h00, 0, rd); chk("R5 id write dropped", rd, ID0);
    loc_acc(0, 8'h40, 0, rd); chk("R5 std filler", rd, FIL);
    loc_acc(1, 8'h8C, 32'h7777_1AB0, rd);
    loc_acc(0, 8'h9C, 0, rd); chk("R5 override readable", rd, ID0);
  endtask

  task automatic t_collide;
    @(negedge clk);
    loc_req = 1; loc_we = 0; loc_addr = 8'h44;
    pci_req = 1; pci_we = 0; pci_addr = 8'h00; pci_be = 4'hF;
    @(negedge clk);
    loc_req = 0; pci_req = 0;
    chk("R11 pci retried", {30'd0, pci_rsp}, 1);
    chk("R11 local served", loc_rdata, 32'hCAFE_0044);
  endtask

  task automatic t_release;
    logic [31:0] rd; logic [1:0] rsp;
    loc_acc(1, 8'hFC, 32'h0, rd);
    loc_acc(0, 8'h44, 0, rd); chk("R4 flush read filler", rd, FIL);
    loc_acc(0, 8'h00, 0, rd); chk("R4 id filler", rd, FIL);
    loc_acc(0, 8'hFC, 0, rd); chk("R4 hold clear", rd, 0);
    loc_acc(1, 8'h9C, 32'hBEEF_1234, rd);
    pci_acc(0, 8'h00, 0, 4'hF, rsp, rd); chk("R6 id override", rd, 32'hBEEF_1234);
    chk("R7 id read done", {30'd0, rsp}, 0);
    loc_acc(1, 8'hA0, 32'h0C03_0099, rd);
    pci_acc(0, 8'h08, 0, 4'hF, rsp, rd); chk("R6 class override", rd, 32'h0C03_0099);
    pci_acc(0, 8'h2C, 0, 4'hF, rsp, rd); chk("R8 subsystem mirror", rd, 32'h7777_1AB0);
    loc_acc(1, 8'h8C, 32'h4242_0001, rd);
    pci_acc(0, 8'h2C, 0, 4'hF, rsp, rd); chk("R8 subsystem update", rd, 32'h4242_0001);
    pci_acc(1, 8'h40, 32'hAABB_CCDD, 4'b0011, rsp, rd); chk("R7 std write done", {30'd0, rsp}, 0);
    pci_acc(0, 8'h40, 0, 4'hF, rsp, rd); chk("R7 byte enables", rd, 32'h0000_CCDD);
    pci_acc(1, 8'h00, 32'h0, 4'hF, rsp, rd); chk("R7 id write ignored", {30'd0, rsp}, 2);
    pci_acc(0, 8'h00, 0, 4'hF, rsp, rd); chk("R7 id kept", rd, 32'hBEEF_1234);
    pci_acc(0, 8'h44, 0, 4'hF, rsp, rd); chk("R7 map filler", rd, FIL);
    pci_acc(1, 8'h9C, 32'h0102_0304, 4'hF, rsp, rd); chk("R10 new rev ignores", {30'd0, rsp}, 2);
    chk("R10 old rev writes", {30'd0, o_pci_rsp}, 0);
    pci_acc(0, 8'h9C, 0, 4'hF, rsp, rd); chk("R10 old rev std read", o_pci_rdata, 32'h0102_0304);
    chk("R10 new rev filler", rd, FIL);
    pci_acc(0, 8'h00, 0, 4'hF, rsp, rd); chk("R10 old rev id param", o_pci_rdata, ID0);
  endtask

  task automatic t_host;
    logic [31:0] rd; logic [1:0] rsp;
    do_reset(1'b1);
    loc_acc(0, 8'h40, 0, rd); chk("R9 std valid", rd, 0);
    loc_acc(1, 8'h40, 32'h1357_9BDF, rd);
    loc_acc(0, 8'h40, 0, rd); chk("R9 std write", rd, 32'h1357_9BDF);
    loc_acc(1, 8'h08, 32'h0, rd);
    loc_acc(0, 8'h08, 0, rd); chk("R9 id write dropped", rd, CL0);
    pci_acc(0, 8'h40, 0, 4'hF, rsp, rd); chk("R9 pci read filler", rd, FIL);
    chk("R9 pci read done", {30'd0, rsp}, 0);
    pci_acc(1, 8'h40, 32'h0, 4'hF, rsp, rd); chk("R9 pci write ignored", {30'd0, rsp}, 2);
    loc_acc(0, 8'h40, 0, rd); chk("R9 std unchanged", rd, 32'h1357_9BDF);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL R12 watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_held();
    t_collide();
    t_release();
    t_host();
    finish_run();
  end
endmodule